// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit microcontroller core. Five sources feed it: two active-low external pins, two timer overflow flags, and one serial flag that is the OR of the receive and transmit flags. The controller holds a global enable and a per-source enable, a per-source priority bit, and a trigger-mode bit for each external pin. It also holds the request flags for the external pins. The timer and serial flags belong to their engines and arrive here as inputs.

The core gives a one-clock machine-cycle strobe `mc_tick` and a flag `instr_last` that marks the last machine cycle of an instruction. On each strobe the controller samples the pins and polls the flags. It then either arms a vector or does nothing. On the next strobe it issues the vector address together with a push-PC request. It records which priority levels are in service. A return-from-interrupt strobe releases the highest of them.

The sequencer has three states. `ST_IDLE` goes to `ST_ARMED` on a strobe when a request may be taken and `instr_last` is low. At that point it latches the winning source and its level. `ST_ARMED` goes to `ST_VECTOR` on the next strobe. `ST_VECTOR` lasts one clock, drives `vec_valid`, sets the in-service bit and clears the flags that hardware owns. It then returns to `ST_IDLE` without a condition.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `vec_valid`, `tmr_clr`, `in_service` and `ext_flag` are all zero, and all configuration registers are zero.
- R2: Vector addresses by source: external 0 gives 0x0003, timer 0 gives 0x000B, external 1 gives 0x0013, timer 1 gives 0x001B, and serial gives 0x0023.
- R3: Register address 0 is the enable register. Bit 7 is the global enable. Bits 0..4 enable external 0, timer 0, external 1, timer 1 and serial, in that order. A source vectors only when its own bit and bit 7 are both 1.
- R4: Register address 1 is the priority register. Its bits 0..4 use the same source order as the enable register, and a 1 means high priority. A pending enabled high source always wins over a low one. Within one level the fixed order is external 0, timer 0, external 1, timer 1, serial.
- R5: While a low handler is in service, only high requests are accepted. While a high handler is in service, nothing is accepted. `in_service` bit 1 marks the high level and bit 0 marks the low level.
- R6: A strobe with `instr_last` high accepts no request.
- R7: A request accepted on strobe k gives a `vec_valid` pulse of exactly one clock. The pulse starts right after strobe k+1.
- R8: Register address 2 bit i set to 1 puts pin i in edge mode. In edge mode the flag sets only when a high sample is followed by a low sample on the next strobe. The flag clears when that pin vectors.
- R9: In level mode the pin flag equals the inverse of the last strobe sample of the pin. Vectoring does not clear it.
- R10: `tmr_clr[i]` pulses together with `vec_valid` when timer i vectors. No clear is ever produced for the serial flags, so a serial flag that stays set requests again.
- R11: A `reti` pulse clears the highest set `in_service` bit. `in_service` changes only on `reti` or on a vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_tick | input | 1 | One-clock strobe per machine cycle |
| instr_last | input | 1 | Current machine cycle is the last of its instruction |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register select: 0 enable, 1 priority, 2 trigger mode |
| reg_wdata | input | 8 | Register write data |
| ext_n | input | 2 | External request pins, active low |
| tmr_flag | input | 2 | Timer overflow flags |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| reti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | Push-PC and load-vector request |
| vec_addr | output | 16 | Vector address, valid while `vec_valid` is high |
| tmr_clr | output | 2 | Timer flag clear pulses |
| ext_flag | output | 2 | External request flags |
| in_service | output | 2 | In-service levels: bit 1 high, bit 0 low |

## Verification
The hardest situation to reach is a nested one. A high serial handler preempts a low timer handler. After the first `reti` the serial flag is still set, so it must vector again. The low request must stay blocked until both levels are released. The bench builds this step by step from the ports. It enters a low timer handler first, shows that a second request at the same level is held, raises the serial flag at high priority, and then releases the levels one `reti` at a time. After each step it checks `in_service` and whether a vector appears. Edge-mode sampling also needs a deliberate high strobe followed by a low strobe. A pin that is low from reset must be shown never to set the flag.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NSRC = 5;
    localparam int NEXT = 2;
    localparam int NTMR = 2;
    localparam int IW   = $clog2(NSRC);

    // source indices, also the in-level polling order
    localparam int SRC_EXT0 = 0;
    localparam int SRC_TMR0 = 1;
    localparam int SRC_EXT1 = 2;
    localparam int SRC_TMR1 = 3;
    localparam int SRC_SER  = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_VECTOR = 2'd2
    } pic_state_e;
endpackage

// File: rtl/pic_pin_sampler.sv
module pic_pin_sampler #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic [NPIN-1:0] pin_n,
    input  logic [NPIN-1:0] edge_mode,
    input  logic [NPIN-1:0] clr,
    output logic [NPIN-1:0] flag
);
    logic [NPIN-1:0] samp_q;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                samp_q[g] <= 1'b0;
                flag[g]   <= 1'b0;
            end else if (tick) begin
                samp_q[g] <= pin_n[g];
                if (!edge_mode[g]) begin
                    flag[g] <= ~pin_n[g];
                end else if (samp_q[g] && !pin_n[g]) begin
                    flag[g] <= 1'b1;
                end else if (clr[g]) begin
                    flag[g] <= 1'b0;
                end
            end else if (clr[g] && edge_mode[g]) begin
                flag[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pic_select.sv
module pic_select
    import pic_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]  req,
    input  logic [N-1:0]  en,
    input  logic [N-1:0]  prio,
    input  logic          ea,
    input  logic [1:0]    insvc,
    output logic          hit,
    output logic [IW-1:0] idx,
    output logic          lvl
);
    logic [N-1:0] hi_cand;
    logic [N-1:0] lo_cand;
    logic [N-1:0] pick;

    always_comb begin
        hi_cand = req & en & prio  & {N{ea && !insvc[1]}};
        lo_cand = req & en & ~prio & {N{ea && (insvc == 2'b00)}};
        lvl     = |hi_cand;
        pick    = lvl ? hi_cand : lo_cand;
        hit     = |pick;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pick[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/pic_seq.sv
module pic_seq
    import pic_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          instr_last,
    input  logic          hit,
    input  logic [IW-1:0] idx,
    input  logic          lvl,
    input  logic          reti,
    output logic          vec_valid,
    output logic [IW-1:0] vec_idx,
    output logic [1:0]    insvc
);
    pic_state_e    state_q, state_d;
    logic [IW-1:0] idx_q;
    logic          lvl_q;
    logic [1:0]    insvc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_ARMED) begin
                idx_q <= idx;
                lvl_q <= lvl;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (tick && hit && !instr_last) state_d = ST_ARMED;
            ST_ARMED:  if (tick) state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        vec_valid = (state_q == ST_VECTOR);
        vec_idx   = idx_q;
    end

    always_comb begin
        insvc_d = insvc;
        if (reti) begin
            if (insvc[1]) insvc_d[1] = 1'b0;
            else          insvc_d[0] = 1'b0;
        end
        if (vec_valid) insvc_d[lvl_q] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) insvc <= 2'b00;
        else        insvc <= insvc_d;
    end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter int AW         = 16,
    parameter int VEC_BASE   = 3,
    parameter int VEC_STRIDE = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mc_tick,
    input  logic          instr_last,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [7:0]    reg_wdata,
    input  logic [1:0]    ext_n,
    input  logic [1:0]    tmr_flag,
    input  logic          ser_rx,
    input  logic          ser_tx,
    input  logic          reti,
    output logic          vec_valid,
    output logic [AW-1:0] vec_addr,
    output logic [1:0]    tmr_clr,
    output logic [1:0]    ext_flag,
    output logic [1:0]    in_service
);
    logic            ea_q;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] prio_q;
    logic [NEXT-1:0] edge_q;
    logic            unused_wbits;

    assign unused_wbits = ^reg_wdata[6:5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ea_q   <= 1'b0;
            en_q   <= '0;
            prio_q <= '0;
            edge_q <= '0;
        end else if (reg_we) begin
            unique case (reg_addr)
                2'd0: begin
                    ea_q <= reg_wdata[7];
                    en_q <= reg_wdata[NSRC-1:0];
                end
                2'd1: prio_q <= reg_wdata[NSRC-1:0];
                2'd2: edge_q <= reg_wdata[NEXT-1:0];
                default: ;
            endcase
        end
    end

    logic [NSRC-1:0] req;
    logic            hit, lvl;
    logic [IW-1:0]   idx, vec_idx;
    logic [NEXT-1:0] ext_clr;

    assign req = {ser_rx | ser_tx, tmr_flag[1], ext_flag[1], tmr_flag[0], ext_flag[0]};

    assign ext_clr[0] = vec_valid && (vec_idx == IW'(SRC_EXT0));
    assign ext_clr[1] = vec_valid && (vec_idx == IW'(SRC_EXT1));
    assign tmr_clr[0] = vec_valid && (vec_idx == IW'(SRC_TMR0));
    assign tmr_clr[1] = vec_valid && (vec_idx == IW'(SRC_TMR1));
    assign vec_addr   = AW'(VEC_BASE + int'(vec_idx) * VEC_STRIDE);

    pic_pin_sampler #(.NPIN(NEXT)) u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (mc_tick),
        .pin_n     (ext_n),
        .edge_mode (edge_q),
        .clr       (ext_clr),
        .flag      (ext_flag)
    );

    pic_select #(.N(NSRC)) u_sel (
        .req   (req),
        .en    (en_q),
        .prio  (prio_q),
        .ea    (ea_q),
        .insvc (in_service),
        .hit   (hit),
        .idx   (idx),
        .lvl   (lvl)
    );

    pic_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (mc_tick),
        .instr_last (instr_last),
        .hit        (hit),
        .idx        (idx),
        .lvl        (lvl),
        .reti       (reti),
        .vec_valid  (vec_valid),
        .vec_idx    (vec_idx),
        .insvc      (in_service)
    );
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          vec_valid,
    input logic [AW-1:0] vec_addr,
    input logic [1:0]    tmr_clr,
    input logic          reti,
    input logic [1:0]    in_service
);
    // R7
    vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    // R2
    vec_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_addr[2:0] == 3'b011 && vec_addr <= AW'(16'h0023)));

    // R10
    tmr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tmr_clr) |-> vec_valid);

    // R11
    insvc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid && !reti) |=> $stable(in_service));

    // R5
    insvc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> (in_service != 2'b00));
endmodule

bind pic_ctrl pic_ctrl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .vec_valid  (vec_valid),
    .vec_addr   (vec_addr),
    .tmr_clr    (tmr_clr),
    .reti       (reti),
    .in_service (in_service)
);

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0;
    logic        instr_last = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [1:0]  ext_n = 2'b11;
    logic [1:0]  tmr_flag = '0;
    logic        ser_rx = 1'b0;
    logic        ser_tx = 1'b0;
    logic        reti = 1'b0;
    logic        vec_valid;
    logic [15:0] vec_addr;
    logic [1:0]  tmr_clr;
    logic [1:0]  ext_flag;
    logic [1:0]  in_service;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pic_ctrl dut (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .instr_last(instr_last),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .ext_n(ext_n), .tmr_flag(tmr_flag), .ser_rx(ser_rx), .ser_tx(ser_tx),
        .reti(reti), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .tmr_clr(tmr_clr), .ext_flag(ext_flag), .in_service(in_service)
    );

    typedef struct packed {
        logic [7:0] ie;
        logic [4:0] ip;
        logic [1:0] extn;
        logic [1:0] tmr;
        logic       ser;
        logic       expv;
        logic [7:0] expa;
    } vec_t;

    localparam int NT = 10;
    localparam vec_t TBL [NT] = '{
        '{8'h9F, 5'h00, 2'b11, 2'b11, 1'b1, 1'b1, 8'h0B},
        '{8'h9F, 5'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h03},
        '{8'h9F, 5'h10, 2'b00, 2'b11, 1'b1, 1'b1, 8'h23},
        '{8'h9F, 5'h08, 2'b00, 2'b11, 1'b1, 1'b1, 8'h1B},
        '{8'h1F, 5'h00, 2'b00, 2'b11, 1'b1, 1'b0, 8'h00},
        '{8'h9C, 5'h00, 2'b00, 2'b11, 1'b1, 1'b1, 8'h13},
        '{8'h90, 5'h00, 2'b11, 2'b11, 1'b0, 1'b0, 8'h00},
        '{8'h88, 5'h00, 2'b11, 2'b10, 1'b0, 1'b1, 8'h1B},
        '{8'h9F, 5'h05, 2'b00, 2'b11, 1'b1, 1'b1, 8'h03},
        '{8'h9E, 5'h05, 2'b00, 2'b11, 1'b1, 1'b1, 8'h13}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; mc_tick = 1'b0; instr_last = 1'b0; reg_we = 1'b0;
        ext_n = 2'b11; tmr_flag = '0; ser_rx = 1'b0; ser_tx = 1'b0; reti = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_reti();
        @(negedge clk);
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    // one machine cycle: strobe, then look right after the strobe edge
    task automatic mcyc(output logic v, output logic [15:0] a, output logic [1:0] tc);
        @(negedge clk);
        mc_tick = 1'b1;
        @(negedge clk);
        mc_tick = 1'b0;
        v = vec_valid; a = vec_addr; tc = tmr_clr;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic v;
        logic [15:0] a;
        logic [1:0] tc;

        // R1 reset state
        do_reset();
        check("R1 vec_valid", 32'(vec_valid), 32'd0);
        check("R1 in_service", 32'(in_service), 32'd0);
        check("R1 ext_flag", 32'(ext_flag), 32'd0);
        check("R1 tmr_clr", 32'(tmr_clr), 32'd0);

        // table: R2 R3 R4 R7 under several request patterns (level mode)
        for (int i = 0; i < NT; i++) begin
            do_reset();
            ext_n = TBL[i].extn; tmr_flag = TBL[i].tmr; ser_rx = TBL[i].ser;
            mcyc(v, a, tc);
            wr(2'd1, {3'b000, TBL[i].ip});
            wr(2'd0, TBL[i].ie);
            mcyc(v, a, tc);
            check($sformatf("R7 no vector on polling strobe row %0d", i), 32'(v), 32'd0);
            mcyc(v, a, tc);
            check($sformatf("R3 R4 vector presence row %0d", i), 32'(v), 32'(TBL[i].expv));
            if (TBL[i].expv)
                check($sformatf("R2 R4 vector address row %0d", i), 32'(a), 32'(TBL[i].expa));
        end

        // R6 instr_last blocks acceptance; R10 timer clear pulse
        do_reset();
        tmr_flag = 2'b01;
        wr(2'd0, 8'h82);
        instr_last = 1'b1;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R6 no vector with instr_last", 32'(v), 32'd0);
        instr_last = 1'b0;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R6 vector after instr_last low", 32'(a), 32'h000B);
        check("R10 timer0 clear pulse", 32'(tc), 32'b01);

        // R8 edge mode
        do_reset();
        wr(2'd2, 8'h01);
        ext_n = 2'b10;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R8 low since reset sets no flag", 32'(ext_flag[0]), 32'd0);
        ext_n = 2'b11;
        mcyc(v, a, tc);
        ext_n = 2'b10;
        mcyc(v, a, tc);
        check("R8 high then low sets flag", 32'(ext_flag[0]), 32'd1);
        wr(2'd0, 8'h81);
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R8 edge vector", 32'(a), 32'h0003);
        check("R8 flag cleared on vector", 32'(ext_flag[0]), 32'd0);
        pulse_reti();
        mcyc(v, a, tc);
        check("R8 steady low gives no new flag", 32'(ext_flag[0]), 32'd0);

        // R9 level mode
        do_reset();
        ext_n = 2'b01;
        mcyc(v, a, tc);
        check("R9 level flag follows pin", 32'(ext_flag[1]), 32'd1);
        wr(2'd0, 8'h84);
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R9 level vector", 32'(a), 32'h0013);
        check("R9 flag kept after vector", 32'(ext_flag[1]), 32'd1);
        ext_n = 2'b11;
        mcyc(v, a, tc);
        check("R9 flag drops with pin", 32'(ext_flag[1]), 32'd0);

        // R5 R10 R11 nesting
        do_reset();
        wr(2'd1, 8'h10);
        wr(2'd0, 8'h92);
        tmr_flag = 2'b01;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R5 low timer vector", 32'(a), 32'h000B);
        tmr_flag = 2'b00;
        check("R5 low level in service", 32'(in_service), 32'b01);
        tmr_flag = 2'b01;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R5 same level held", 32'(v), 32'd0);
        ser_tx = 1'b1;
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R5 high preempts low", 32'(a), 32'h0023);
        check("R5 both levels in service", 32'(in_service), 32'b11);
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R5 nothing while high in service", 32'(v), 32'd0);
        pulse_reti();
        check("R11 reti releases high first", 32'(in_service), 32'b01);
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R10 serial flag not cleared, revectors", 32'(a), 32'h0023);
        ser_tx = 1'b0;
        pulse_reti();
        pulse_reti();
        check("R11 all levels released", 32'(in_service), 32'b00);
        mcyc(v, a, tc);
        mcyc(v, a, tc);
        check("R5 held low request taken after release", 32'(a), 32'h000B);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule